// File: doc/BRIEF.md
# Fabric Frame Receive Decoder

This block sits on the receive side of a 32-bit fabric link. Each word arrives with one parity bit, and a start strobe marks the first word of every frame. The block turns a data frame back into the 44-bit transmit-side form: first one instruction word, then the payload words. It marks the first word of each frame and the end of each data frame. It also reports two parity results for the frame. The horizontal result is a per-word odd-parity check. The vertical result compares the running XOR of the frame with the trailer word.

A data frame has this layout. The header word carries the strobe. It holds a data flag in bit 31, a payload length in bits 30:24 and the upper 12 instruction bits in bits 11:0. Bits 23:12 are reserved. The next word holds the lower 32 instruction bits. Then come as many payload words as the length field gives, and a trailer word last. An idle frame is one strobed word with bit 31 clear. Words that arrive outside a frame without the strobe are dead cycles.

Every result leaves through a fixed register pipeline. So every output lags the input word that caused it by exactly the same number of cycles, whatever kind of word it is.

Top module: `frame_rx_decoder`

## Requirements
- R1: While reset is active and after it is released, every output is zero until an input word's result reaches the outputs.
- R2: A word presented on the inputs in cycle t produces its result on the outputs in cycle t+5, with no other delay.
- R3: A strobed word with bit 31 set starts a data frame. The next word appears on out_bus as {header bits 11:0, that word}, with out_valid and out_inst high.
- R4: Header bits 30:24 give the payload count L. The L words after the instruction word each appear as {12'b0, word} with out_valid high and out_inst low, in arrival order.
- R5: frame_start is high for one cycle for every strobed word, whether the frame is a data frame or an idle frame.
- R6: A strobed word with bit 31 clear is an idle frame. It raises frame_start only, with no out_valid and no xfer_end.
- R7: xfer_end is high for exactly one cycle, for the trailer word that follows the L payload words. It never coincides with frame_start.
- R8: vpar_ok is high with xfer_end when the trailer equals the XOR of the header, the instruction-low word and all payload words. It is low whenever xfer_end is low.
- R9: hpar_ok is high with xfer_end when every word of the frame, trailer included, has odd parity over {word, parity bit}. It is low whenever xfer_end is low.
- R10: Words without the strobe that arrive outside a frame produce no output.
- R11: A strobed word inside a frame abandons that frame without xfer_end, and it is decoded as a new header.
- R12: out_bus is zero whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 32 | Received fabric word |
| rx_par | input | 1 | Odd-parity bit for rx_word |
| rx_sof | input | 1 | Start-of-frame strobe, high on the header word |
| out_bus | output | 44 | Rebuilt instruction or payload word |
| out_valid | output | 1 | out_bus carries a word |
| out_inst | output | 1 | out_bus carries the instruction word |
| frame_start | output | 1 | A frame header was received |
| xfer_end | output | 1 | A data frame ended with its trailer |
| vpar_ok | output | 1 | Vertical parity matched, valid with xfer_end |
| hpar_ok | output | 1 | All word parities were good, valid with xfer_end |

## Verification
A wrong frame state or a wrong payload count shows up at the outputs within five cycles of the word that exposes it. Such a fault can mark a payload word as the instruction word, raise xfer_end one word early or late, or emit data on a dead cycle. A stale accumulator or a stale parity flag shows up only at the trailer, as a wrong vpar_ok or hpar_ok. A mishandled abort shows up as a missing or spurious xfer_end, or as a new header that is not decoded. The bench therefore mixes frames of many lengths, corrupted trailers, bad parity bits, idle frames, dead gaps and frames cut short by a new strobe.

// File: rtl/frx_pkg.sv
package frx_pkg;
   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_INST = 2'd1,
      ST_BODY = 2'd2,
      ST_TAIL = 2'd3
   } frx_state_e;
endpackage

// File: rtl/frx_capture.sv
module frx_capture #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_word,
   input  logic              in_par,
   input  logic              in_sof,
   output logic [DATA_W-1:0] c_word,
   output logic              c_sof,
   output logic              c_pok
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_word <= '0;
         c_sof  <= 1'b0;
         c_pok  <= 1'b0;
      end else begin
         c_word <= in_word;
         c_sof  <= in_sof;
         c_pok  <= ^{in_word, in_par};
      end
   end
endmodule

// File: rtl/frx_decode.sv
module frx_decode
   import frx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int OUT_W  = 44,
   parameter int LEN_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] c_word,
   input  logic              c_sof,
   input  logic              c_pok,
   output logic              o_valid,
   output logic              o_inst,
   output logic [OUT_W-1:0]  o_bus,
   output logic              o_start,
   output logic              o_eot,
   output logic              o_vok,
   output logic              o_hok
);
   localparam int HI_W    = OUT_W - DATA_W;
   localparam int FLAG_B  = DATA_W - 1;
   localparam int LEN_TOP = DATA_W - 2;

   frx_state_e        st;
   logic [HI_W-1:0]   inst_hi;
   logic [DATA_W-1:0] vacc;
   logic              hgood;
   logic [LEN_W-1:0]  remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_WAIT;
         inst_hi <= '0;
         vacc    <= '0;
         hgood   <= 1'b0;
         remain  <= '0;
         o_valid <= 1'b0;
         o_inst  <= 1'b0;
         o_bus   <= '0;
         o_start <= 1'b0;
         o_eot   <= 1'b0;
         o_vok   <= 1'b0;
         o_hok   <= 1'b0;
      end else begin
         o_valid <= 1'b0;
         o_inst  <= 1'b0;
         o_bus   <= '0;
         o_start <= 1'b0;
         o_eot   <= 1'b0;
         o_vok   <= 1'b0;
         o_hok   <= 1'b0;
         if (c_sof) begin
            // a strobe always opens a new frame, abandoning any open one
            o_start <= 1'b1;
            if (c_word[FLAG_B]) begin
               st      <= ST_INST;
               inst_hi <= c_word[HI_W-1:0];
               vacc    <= c_word;
               hgood   <= c_pok;
               remain  <= c_word[LEN_TOP -: LEN_W];
            end else begin
               st <= ST_WAIT;
            end
         end else begin
            unique case (st)
               ST_INST: begin
                  o_valid <= 1'b1;
                  o_inst  <= 1'b1;
                  o_bus   <= {inst_hi, c_word};
                  vacc    <= vacc ^ c_word;
                  hgood   <= hgood & c_pok;
                  st      <= (remain == '0) ? ST_TAIL : ST_BODY;
               end
               ST_BODY: begin
                  o_valid <= 1'b1;
                  o_bus   <= {{HI_W{1'b0}}, c_word};
                  vacc    <= vacc ^ c_word;
                  hgood   <= hgood & c_pok;
                  remain  <= remain - LEN_W'(1);
                  if (remain == LEN_W'(1)) st <= ST_TAIL;
               end
               ST_TAIL: begin
                  o_eot <= 1'b1;
                  o_vok <= (vacc == c_word);
                  o_hok <= hgood & c_pok;
                  st    <= ST_WAIT;
               end
               default: begin
                  st <= ST_WAIT;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/frx_delay.sv
module frx_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_pass
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] stage [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
            end else begin
               stage[0] <= d;
               for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
            end
         end
         assign q = stage[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/frame_rx_decoder.sv
module frame_rx_decoder #(
   parameter int DATA_W = 32,
   parameter int OUT_W  = 44,
   parameter int LEN_W  = 7,
   parameter int LAT    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rx_par,
   input  logic              rx_sof,
   output logic [OUT_W-1:0]  out_bus,
   output logic              out_valid,
   output logic              out_inst,
   output logic              frame_start,
   output logic              xfer_end,
   output logic              vpar_ok,
   output logic              hpar_ok
);
   localparam int HI_W  = OUT_W - DATA_W;
   localparam int PK_W  = OUT_W + 6;
   localparam int DLY   = LAT - 2;

   if (HI_W < 1) begin : g_chk_w
      $error("OUT_W must exceed DATA_W");
   end
   if (HI_W + LEN_W + 1 > DATA_W) begin : g_chk_hdr
      $error("header fields overlap");
   end
   if (LAT < 2) begin : g_chk_lat
      $error("LAT must be at least 2");
   end

   logic [DATA_W-1:0] c_word;
   logic              c_sof, c_pok;
   logic              d_valid, d_inst, d_start, d_eot, d_vok, d_hok;
   logic [OUT_W-1:0]  d_bus;
   logic [PK_W-1:0]   pk_in, pk_out;

   frx_capture #(.DATA_W(DATA_W)) i_cap (
      .clk(clk), .rst_n(rst_n),
      .in_word(rx_word), .in_par(rx_par), .in_sof(rx_sof),
      .c_word(c_word), .c_sof(c_sof), .c_pok(c_pok)
   );

   frx_decode #(.DATA_W(DATA_W), .OUT_W(OUT_W), .LEN_W(LEN_W)) i_dec (
      .clk(clk), .rst_n(rst_n),
      .c_word(c_word), .c_sof(c_sof), .c_pok(c_pok),
      .o_valid(d_valid), .o_inst(d_inst), .o_bus(d_bus),
      .o_start(d_start), .o_eot(d_eot), .o_vok(d_vok), .o_hok(d_hok)
   );

   assign pk_in = {d_valid, d_inst, d_bus, d_start, d_eot, d_vok, d_hok};

   frx_delay #(.W(PK_W), .DEPTH(DLY)) i_dly (
      .clk(clk), .rst_n(rst_n), .d(pk_in), .q(pk_out)
   );

   assign {out_valid, out_inst, out_bus, frame_start, xfer_end, vpar_ok, hpar_ok} = pk_out;
endmodule

// File: rtl/frx_checker.sv
module frx_checker #(
   parameter int OUT_W = 44,
   parameter int LAT   = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_sof,
   input logic [OUT_W-1:0] out_bus,
   input logic             out_valid,
   input logic             out_inst,
   input logic             frame_start,
   input logic             xfer_end,
   input logic             vpar_ok,
   input logic             hpar_ok
);
   logic [LAT-1:0] sof_hist;

   always_ff @(posedge clk) begin
      if (!rst_n) sof_hist <= '0;
      else        sof_hist <= {sof_hist[LAT-2:0], rx_sof};
   end

   // R5 with R2: a start indication traces back to a strobe LAT cycles earlier
   p_start_after_sof_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> sof_hist[LAT-1]);
   p_bus_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_bus == '0));
   p_inst_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_inst |-> out_valid);
   p_eot_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |-> !frame_start);
   p_eot_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |=> !xfer_end);
   p_vok_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_end |-> !vpar_ok);
   p_hok_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_end |-> !hpar_ok);
endmodule

bind frame_rx_decoder frx_checker #(.OUT_W(OUT_W), .LAT(LAT)) i_frx_checker (
   .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .out_bus(out_bus),
   .out_valid(out_valid), .out_inst(out_inst), .frame_start(frame_start),
   .xfer_end(xfer_end), .vpar_ok(vpar_ok), .hpar_ok(hpar_ok)
);

// File: tb/test_frame_rx_decoder.sv
module test_frame_rx_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] rx_word = '0;
   logic        rx_par = 1'b1;
   logic        rx_sof = 1'b0;
   logic [43:0] out_bus;
   logic        out_valid, out_inst, frame_start, xfer_end, vpar_ok, hpar_ok;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string scen = "R1";

   always #10 clk = ~clk;

   frame_rx_decoder i_frame_rx_decoder (
      .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_par(rx_par), .rx_sof(rx_sof),
      .out_bus(out_bus), .out_valid(out_valid), .out_inst(out_inst),
      .frame_start(frame_start), .xfer_end(xfer_end), .vpar_ok(vpar_ok), .hpar_ok(hpar_ok)
   );

   typedef struct packed {
      bit        valid;
      bit        inst;
      bit [43:0] bus;
      bit        start;
      bit        eot;
      bit        vok;
      bit        hok;
   } exp_t;

   exp_t        pipe [5];
   int          ms;
   bit [11:0]   mhi;
   bit [31:0]   mv;
   bit          mh;
   int          mlen, mk;

   // reference model from the requirements: result of cycle t visible in t+5
   always @(posedge clk) begin
      exp_t e;
      bit   pok;
      e = '0;
      if (!rst_n) begin
         ms = 0;
         for (int i = 0; i < 5; i++) pipe[i] = '0;
      end else begin
         pok = ^{rx_word, rx_par};
         if (rx_sof) begin
            e.start = 1;
            if (rx_word[31]) begin
               ms = 1; mhi = rx_word[11:0]; mv = rx_word; mh = pok;
               mlen = int'(rx_word[30:24]); mk = 0;
            end else ms = 0;
         end else if (ms == 1) begin
            e.valid = 1; e.inst = 1; e.bus = {mhi, rx_word};
            mv = mv ^ rx_word; mh = mh & pok;
            ms = (mlen == 0) ? 3 : 2;
         end else if (ms == 2) begin
            e.valid = 1; e.bus = {12'h0, rx_word};
            mv = mv ^ rx_word; mh = mh & pok; mk++;
            if (mk == mlen) ms = 3;
         end else if (ms == 3) begin
            e.eot = 1; e.vok = (mv == rx_word); e.hok = mh & pok; ms = 0;
         end
         for (int i = 4; i > 0; i--) pipe[i] = pipe[i-1];
         pipe[0] = e;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] actual=%h expected=%h at %0t", req, scen, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         exp_t x;
         x = pipe[4];
         if (x.valid || out_valid || out_inst || out_bus != 0)
            check(x.inst ? "R2 R3" : (x.valid ? "R2 R4" : "R12"),
                  {18'h0, out_valid, out_inst, out_bus}, {18'h0, x.valid, x.inst, x.bus});
         if (x.start || frame_start) check("R5", 64'(frame_start), 64'(x.start));
         if (x.eot || xfer_end)      check("R7", 64'(xfer_end), 64'(x.eot));
         if (x.vok || vpar_ok)       check("R8", 64'(vpar_ok), 64'(x.vok));
         if (x.hok || hpar_ok)       check("R9", 64'(hpar_ok), 64'(x.hok));
      end
   end

   task automatic put(input logic [31:0] w, input bit s, input bit bad);
      @(negedge clk);
      rx_word = w; rx_sof = s; rx_par = (~^w) ^ bad;
   endtask

   task automatic gap(input int n);
      for (int i = 0; i < n; i++) put($urandom, 1'b0, $urandom_range(0, 1) == 1);
   endtask

   task automatic idle_frame();
      put({1'b0, 31'($urandom)}, 1'b1, 1'b0);
   endtask

   // bad_idx / abort_at count words from 0 = header; -1 disables
   task automatic data_frame(input int len, input bit bad_tr, input int bad_idx, input int abort_at);
      logic [31:0] w, acc;
      int          total;
      total = len + 3;
      acc = '0;
      for (int i = 0; i < total; i++) begin
         if (i == abort_at) return;
         if (i == 0) w = {1'b1, 7'(len), 24'($urandom)};
         else if (i == total - 1) w = acc ^ (bad_tr ? 32'h0000_0100 : 32'h0);
         else w = $urandom;
         if (i != total - 1) acc = acc ^ w;
         put(w, i == 0, i == bad_idx);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      scen = "R1";
      check("R1", {19'h0, out_valid, out_inst, frame_start, xfer_end, vpar_ok, hpar_ok, out_bus},
            64'h0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", {19'h0, out_valid, out_inst, frame_start, xfer_end, vpar_ok, hpar_ok, out_bus},
            64'h0);

      scen = "R10 dead cycles";   gap(6);
      scen = "R6 idle";           idle_frame(); gap(4); idle_frame(); idle_frame(); gap(6);
      scen = "R3 zero length";    data_frame(0, 0, -1, -1); gap(6);
      scen = "R4 payload";        data_frame(3, 0, -1, -1); gap(6);
      scen = "R2 back to back";   data_frame(2, 0, -1, -1); data_frame(1, 0, -1, -1); idle_frame();
      scen = "R8 bad trailer";    data_frame(4, 1, -1, -1); gap(3);
      scen = "R9 bad parity";     data_frame(4, 0, 3, -1); data_frame(2, 0, 4, -1); gap(3);
      scen = "R11 abort";         data_frame(5, 0, -1, 4); data_frame(2, 0, -1, -1);
                                  data_frame(3, 0, -1, 1); idle_frame(); gap(6);
      scen = "R4 long";           data_frame(40, 0, -1, -1); gap(6);

      scen = "random";
      for (int n = 0; n < 300; n++) begin
         int kind;
         kind = $urandom_range(0, 9);
         if (kind == 0) idle_frame();
         else data_frame($urandom_range(0, 9), $urandom_range(0, 4) == 0,
                         ($urandom_range(0, 4) == 0) ? $urandom_range(0, 5) : -1,
                         ($urandom_range(0, 6) == 0) ? $urandom_range(1, 6) : -1);
         if ($urandom_range(0, 2) == 0) gap($urandom_range(1, 4));
      end
      gap(10);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog [%s] actual=running expected=finished", scen);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule